// File: doc/BRIEF.md
# Shared Open-Load Delay Monitor

This block watches a bank of half-bridge drivers for open-load (under-load) conditions and decides when a persistent one becomes a fault. Each driver supplies a comparator flag saying its load current is below the minimum. A driver only counts when it is commanded on and has not already been latched off. All drivers share one delay timer. The first qualifying under-load starts the timer. A driver that becomes under-load while the timer is already running gets only the time that is left, not a fresh delay.

When the timer reaches its delay, the block sets a single sticky fault bit. The drivers that are still under-load at that moment are marked as offending. If the shutdown-enable input is high, each offending driver also gets a latched turn-off request. The fault bit and the turn-off requests stay set until a clear request arrives. The delay is given in clock cycles by a parameter.

The timer is a three-state machine: `TMR_IDLE` (count zero), `TMR_RUN` (counting) and `TMR_HELD` (expired, count held at its terminal value). The transitions are named:
- *start*: IDLE to RUN, on any qualifying under-load.
- *drop*: RUN to IDLE, when no driver is under-load.
- *expire*: RUN to HELD, on the last cycle of the delay.
- *release*: HELD to IDLE, when no driver is under-load.
- *clear*: any state to IDLE, on a clear request.

Top module: `openload_monitor`

## Requirements
- R1: An under-load flag counts only for a driver whose `drv_on` bit is 1 and whose `drv_off` bit is 0; other flags never start the timer, never set the fault and never latch a driver off.
- R2: The timer starts at the first clock edge where any driver qualifies as under-load. `ul_fault` becomes 1 right after the DELAY_CYC-th consecutive edge on which at least one driver qualified.
- R3: The timer is shared. A driver that starts qualifying while the timer runs is handled at the same expiry edge as the driver that started the timer.
- R4: A clock edge on which no driver qualifies returns the timer to zero. The next under-load then needs a full DELAY_CYC consecutive edges.
- R5: At expiry only the drivers still qualifying are acted on. A driver whose flag dropped before expiry is not latched off, even if the timer kept running for another driver.
- R6: With `sd_en`=1 at an expiry edge, each qualifying driver's `drv_off` bit is set. With `sd_en`=0 the fault bit is set and `drv_off` is left unchanged.
- R7: After expiry the timer stays at its terminal count while any driver qualifies. On every such edge, qualifying drivers are handled at once: the fault bit is set and, if `sd_en`=1, their `drv_off` bits are set at that edge.
- R8: `ul_fault` and `drv_off` stay set until `clr_req`=1 is sampled. A clear zeroes them and restarts the timer from zero. A clear wins over an expiry on the same edge.
- R9: After reset, `ul_fault` is 0, `drv_off` is all zero and the timer is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ul_cmp | input | 2*NCH | Per-driver under-load comparator flags (bit 2c low side, 2c+1 high side of channel c) |
| drv_on | input | 2*NCH | Per-driver commanded-on state |
| sd_en | input | 1 | Latch offending drivers off at expiry when 1 |
| clr_req | input | 1 | Clear request for fault bit, latch-offs and timer |
| ul_fault | output | 1 | Sticky under-load fault bit |
| drv_off | output | 2*NCH | Per-driver latched turn-off requests |

## Verification
The bench first checks the edges just before and just after the delay. A timer that is off by one would raise the fault one cycle early or late. It then sets up overlapping under-loads on different drivers. A design with a separate timer per driver would fail to latch the late driver at the shared expiry. A design that forgets to restart would flag a driver that had already recovered. A single quiet cycle in the middle of an episode must restart the count. If it does not, a design that pauses instead of resetting would fault early. The bench also checks that a clear on the expiry edge wins, that a driver switched off never starts the timer, and that the held state acts at once on a late driver once shutdown is enabled. Long seeded random runs with sparse flag changes, occasional clears and changes to `sd_en` are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/ul_mon_pkg.sv
package ul_mon_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_HELD = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/ul_qualify.sv
module ul_qualify #(
    parameter int ND = 6
) (
    input  logic [ND-1:0] ul_cmp,
    input  logic [ND-1:0] drv_on,
    input  logic [ND-1:0] latched,
    output logic [ND-1:0] act,
    output logic          any_act
);

    genvar g;
    generate
        for (g = 0; g < ND; g++) begin : g_drv
            assign act[g] = ul_cmp[g] & drv_on[g] & ~latched[g];
        end
    endgenerate

    assign any_act = |act;

endmodule

// File: rtl/ul_shared_timer.sv
module ul_shared_timer
    import ul_mon_pkg::*;
#(
    parameter int DELAY_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic any_act,
    output logic fire
);

    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] TERM = CW'(DELAY_CYC);

    tmr_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    if (any_act) begin
                        state_d = TMR_RUN;
                        cnt_d   = CW'(1);
                    end
                end
                TMR_RUN: begin
                    if (!any_act) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = TMR_HELD;
                        cnt_d   = TERM;
                    end else begin
                        cnt_d   = cnt_q + CW'(1);
                    end
                end
                TMR_HELD: begin
                    if (!any_act) begin
                        state_d = TMR_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TMR_IDLE: fire = 1'b0;
            TMR_RUN:  fire = any_act && (cnt_q == LAST);
            TMR_HELD: fire = any_act;
            default:  fire = 1'b0;
        endcase
    end

    // R4: a quiet edge brings the count back to zero
    a_r4_quiet_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !any_act |=> (cnt_q == '0));

    // R2: while running, the count stays inside the delay window
    a_r2_run_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN) |-> (cnt_q >= CW'(1) && cnt_q <= LAST));

    // R7: the held state keeps the terminal count
    a_r7_held_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_HELD) |-> (cnt_q == TERM));

    // R8: a clear restarts the timer
    a_r8_clear_timer: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == TMR_IDLE && cnt_q == '0));

endmodule

// File: rtl/ul_fault_latch.sv
module ul_fault_latch #(
    parameter int ND = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fire,
    input  logic          sd_en,
    input  logic [ND-1:0] act,
    output logic          flag_q,
    output logic [ND-1:0] off_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clr) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < ND; g++) begin : g_off
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    off_q[g] <= 1'b0;
                end else if (clr) begin
                    off_q[g] <= 1'b0;
                end else if (fire && sd_en && act[g]) begin
                    off_q[g] <= 1'b1;
                end
            end
        end
    endgenerate

    // R6: a new latch-off only with shutdown enabled
    a_r6_off_needs_sd: assert property (@(posedge clk) disable iff (!rst_n)
        ((off_q & ~$past(off_q)) != '0) |-> $past(sd_en));

    // R5: a new latch-off only for a driver that qualified on that edge
    a_r5_off_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        ((off_q & ~$past(off_q) & ~$past(act)) == '0));

    // R8: fault and latch-offs hold until a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!flag_q && off_q == '0));

endmodule

// File: rtl/openload_monitor.sv
module openload_monitor #(
    parameter int NCH       = 3,
    parameter int DELAY_CYC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NCH-1:0]   ul_cmp,
    input  logic [2*NCH-1:0]   drv_on,
    input  logic               sd_en,
    input  logic               clr_req,
    output logic               ul_fault,
    output logic [2*NCH-1:0]   drv_off
);

    localparam int ND = 2 * NCH;

    logic [ND-1:0] act;
    logic          any_act;
    logic          fire;

    ul_qualify #(.ND(ND)) u_qual (
        .ul_cmp  (ul_cmp),
        .drv_on  (drv_on),
        .latched (drv_off),
        .act     (act),
        .any_act (any_act)
    );

    ul_shared_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_req),
        .any_act (any_act),
        .fire    (fire)
    );

    ul_fault_latch #(.ND(ND)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_req),
        .fire   (fire),
        .sd_en  (sd_en),
        .act    (act),
        .flag_q (ul_fault),
        .off_q  (drv_off)
    );

    // R1: a driver never commanded on is never latched off
    a_r1_off_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_off & ~$past(drv_off) & ~$past(drv_on)) == '0));

    // R2: the fault bit only rises when some driver qualified
    a_r2_rise_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ul_fault) |-> $past(any_act));

endmodule

// File: tb/openload_monitor_tb.sv
module openload_monitor_tb;

    localparam int NCH = 3;
    localparam int ND  = 2 * NCH;
    localparam int D   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] ul_cmp = '0;
    logic [ND-1:0] drv_on = '0;
    logic          sd_en = 1'b0;
    logic          clr_req = 1'b0;
    logic          ul_fault;
    logic [ND-1:0] drv_off;

    int checks = 0;
    int failures = 0;

    int            m_run = 0;
    logic          m_fault = 1'b0;
    logic [ND-1:0] m_off = '0;

    always #4 clk = ~clk;

    openload_monitor #(.NCH(NCH), .DELAY_CYC(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .ul_cmp(ul_cmp), .drv_on(drv_on),
        .sd_en(sd_en), .clr_req(clr_req), .ul_fault(ul_fault), .drv_off(drv_off)
    );

    function automatic logic [ND-1:0] qualify(logic [ND-1:0] c, logic [ND-1:0] o,
                                              logic [ND-1:0] lat);
        return c & o & ~lat;
    endfunction

    task automatic model_edge();
        logic [ND-1:0] a;
        a = qualify(ul_cmp, drv_on, m_off);
        if (clr_req) begin
            m_run = 0; m_fault = 1'b0; m_off = '0;
        end else if (a != '0) begin
            if (m_run < D) m_run++;
            if (m_run >= D) begin
                m_fault = 1'b1;
                if (sd_en) m_off = m_off | a;
            end
        end else begin
            m_run = 0;
        end
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, {25'd0, ul_fault, drv_off}, {25'd0, m_fault, m_off});
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic clear();
        clr_req = 1'b1;
        step("R8 clear");
        clr_req = 1'b0;
        chk("R8 fault cleared", {31'd0, ul_fault}, 32'd0);
        chk("R8 offs cleared", {26'd0, drv_off}, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5813));
        repeat (3) @(negedge clk);
        chk("R9 reset fault", {31'd0, ul_fault}, 32'd0);
        chk("R9 reset offs", {26'd0, drv_off}, 32'd0);
        rst_n = 1'b1;
        drv_on = '1;
        sd_en  = 1'b1;

        // R2: exact delay edge
        ul_cmp = 6'b000001;
        steps(D - 1, "R2 run");
        chk("R2 not yet", {31'd0, ul_fault}, 32'd0);
        step("R2 expire");
        chk("R2 fault set", {31'd0, ul_fault}, 32'd1);
        chk("R6 off set", {26'd0, drv_off}, 32'h01);
        ul_cmp = '0;
        clear();

        // R4: a gap restarts the count
        ul_cmp = 6'b000010;
        steps(D - 2, "R4 first");
        ul_cmp = '0;
        step("R4 gap");
        ul_cmp = 6'b000010;
        steps(D - 1, "R4 second");
        chk("R4 full delay again", {31'd0, ul_fault}, 32'd0);
        step("R4 expire");
        chk("R4 fault", {31'd0, ul_fault}, 32'd1);
        ul_cmp = '0;
        clear();

        // R3: late driver shares the running timer
        ul_cmp = 6'b000001;
        steps(5, "R3 lead");
        ul_cmp = 6'b010001;
        steps(D - 5, "R3 shared");
        chk("R3 both off at shared expiry", {26'd0, drv_off}, 32'h11);
        ul_cmp = '0;
        clear();

        // R5: a recovered driver is not latched
        ul_cmp = 6'b000101;
        steps(4, "R5 both");
        ul_cmp = 6'b000001;
        steps(D - 4, "R5 one");
        chk("R5 only still-under-load off", {26'd0, drv_off}, 32'h01);
        ul_cmp = '0;
        clear();

        // R1: drivers not on never count
        drv_on = 6'b000000;
        ul_cmp = '1;
        steps(2 * D, "R1 off");
        chk("R1 no fault", {31'd0, ul_fault}, 32'd0);
        drv_on = '1;
        ul_cmp = '0;
        step("R1 idle");

        // R6 / R7: no shutdown, then held state acts at once
        sd_en = 1'b0;
        ul_cmp = 6'b001000;
        steps(D, "R6 nosd");
        chk("R6 fault without off", {31'd0, ul_fault}, 32'd1);
        chk("R6 offs unchanged", {26'd0, drv_off}, 32'd0);
        ul_cmp = 6'b101000;
        sd_en = 1'b1;
        step("R7 held");
        chk("R7 immediate off", {26'd0, drv_off}, 32'h28);

        // R8: clear on expiry edge wins, then full delay
        ul_cmp = '0;
        clear();
        ul_cmp = 6'b000100;
        steps(D - 1, "R8 run");
        clr_req = 1'b1;
        step("R8 clear at expiry");
        clr_req = 1'b0;
        chk("R8 clear wins", {31'd0, ul_fault}, 32'd0);
        steps(D - 1, "R8 restart");
        chk("R8 full delay after clear", {31'd0, ul_fault}, 32'd0);
        step("R8 expire");
        chk("R8 fault after restart", {31'd0, ul_fault}, 32'd1);
        ul_cmp = '0;
        clear();

        // random phase (R3 R5 R7 against model)
        for (int it = 0; it < 4000; it++) begin
            if ($urandom % 6 == 0) ul_cmp[$urandom % ND] ^= 1'b1;
            if ($urandom % 40 == 0) drv_on[$urandom % ND] ^= 1'b1;
            if ($urandom % 60 == 0) sd_en = ~sd_en;
            clr_req = ($urandom % 70 == 0);
            step("R3 R5 R7 random model");
        end
        clr_req = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule